// File: doc/BRIEF.md
# DMA Peripheral Bus Cycle Sequencer

This block carries out the external-bus half of one DMA transfer for whichever channel the DMA core has granted. Once a grant arrives it waits for that channel's request line. It then answers with an active-low acknowledge on that channel's line and pulses exactly one of four active-low command strobes. The strobe is an I/O read or I/O write, or a memory read or memory write when the channel is configured as memory-mapped. When the strobe ends, the acknowledge is released.

The transfer direction picks read or write. A data transfer from the device into memory uses a read command toward the device, and the sequencer captures the device's data on the last strobe cycle. A transfer from memory out to a device uses a write command; the sequencer drives the write data from the acknowledge cycle until one cycle after the strobe is released.

The channel number sets the data width. Channels 0 to 3 move one byte, channels 5 to 7 move two bytes, and channel 4 is never serviced. A small configuration port holds a per-channel memory-mapped select mask and a strobe length in cycles. Both values are latched when a grant is accepted.

Top module: `dma_bus_sequencer`

## Requirements
- R1: A grant is accepted only while the sequencer is idle. A grant naming channel 4 is ignored: no acknowledge, strobe or lane enable follows it, even when request line 4 is high.
- R2: After a grant is accepted, the granted channel's request must be seen high at two consecutive rising edges. `dack_n[ch]` falls at the second of those edges. The command strobe falls one edge later. At most one acknowledge line is ever low.
- R3: If the request is seen high at one edge and low at the next, the transfer is abandoned. No acknowledge or strobe is produced, and the sequencer returns to idle.
- R4: With the memory-mapped bit clear, a grant with `gnt_to_mem`=1 pulses `ior_n` and one with `gnt_to_mem`=0 pulses `iow_n`. No other strobe goes low. The lane enables stay 0 throughout a read.
- R5: Bit i of `cfg_mmio` set makes channel i use `memr_n` in place of `ior_n` and `memw_n` in place of `iow_n`, with unchanged timing.
- R6: The strobe stays low for W consecutive cycles, where W is `cfg_wait`, and a value of 0 gives 1 cycle.
- R7: The acknowledge stays low until the strobe is released and rises at the same edge. It is then high for at least one cycle before it can fall again.
- R8: In a write, the lane enables and `bus_wdata` are active from the acknowledge cycle through the cycle after the strobe rises. The data is the granted `gnt_wdata`.
- R9: Channels 0 to 3 enable lane 0 only (`lane_oe`=01) and return `rd_data[15:8]`=0. Channels 5 to 7 enable both lanes (`lane_oe`=11) and return all 16 bits.
- R10: In a read, `bus_rdata` is sampled at the edge that ends the last strobe cycle. It appears on `rd_data` with `rd_valid` high for exactly that one following cycle.
- R11: `done` is high for one cycle, the cycle after the strobe is released. A configuration write made after a grant does not alter that transfer.
- R12: Out of reset and while idle, all acknowledge and strobe outputs are high, and `lane_oe`, `rd_valid` and `done` are 0. All of these come straight from flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gnt_valid | input | 1 | Grant strobe from the DMA core |
| gnt_ch | input | 3 | Granted channel number |
| gnt_to_mem | input | 1 | 1: device to memory (read command), 0: memory to device (write command) |
| gnt_wdata | input | 16 | Write data for a memory-to-device transfer |
| drq | input | 8 | Per-channel request lines, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_mmio | input | 8 | Per-channel memory-mapped select mask |
| cfg_wait | input | 4 | Strobe length in cycles (0 acts as 1) |
| bus_rdata | input | 16 | Data from the peripheral bus |
| dack_n | output | 8 | Per-channel acknowledges, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| lane_oe | output | 2 | Byte-lane output enables for write data |
| bus_wdata | output | 16 | Write data toward the peripheral bus |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | Transfer completion pulse |

## Verification
The timeline is fixed. A grant presented with its request already high leaves the outputs idle for two cycles. The acknowledge and any write lanes start in the third cycle, the strobe occupies the next W cycles, and the release cycle (carrying `done` and, for a read, `rd_valid`) follows. A late request moves everything except the first idle cycle so that it counts from the edge that first sees the request. The bench puts each of these expected output vectors into a queue at the moment it applies the stimulus. It drives `bus_rdata` with a different value every cycle, so a capture one cycle early or late shows up. It compares one queue entry per clock, at the falling edge, after every register stage has settled.

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer #(
  parameter int NCH    = 8,
  parameter int WAIT_W = 4,
  parameter int DW     = 16,
  parameter int GAP_CH = 4,
  localparam int CW    = $clog2(NCH),
  localparam int HW    = DW / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_valid,
  input  logic [CW-1:0]     gnt_ch,
  input  logic              gnt_to_mem,
  input  logic [DW-1:0]     gnt_wdata,
  input  logic [NCH-1:0]    drq,
  input  logic              cfg_we,
  input  logic [NCH-1:0]    cfg_mmio,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    dack_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic              memr_n,
  output logic              memw_n,
  output logic [1:0]        lane_oe,
  output logic [DW-1:0]     bus_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              done
);

  typedef enum logic [2:0] {S_IDLE, S_WREQ, S_ARM, S_ACK, S_CMD, S_HOLD} st_t;

  st_t               st, st_d;
  logic [CW-1:0]     ch_q;
  logic              to_mem_q, mm_q, wide_q;
  logic [WAIT_W-1:0] wait_q, cnt, wait_r;
  logic [NCH-1:0]    mmio_r;
  logic [DW-1:0]     wdata_q;

  wire accept   = gnt_valid && (gnt_ch != CW'(GAP_CH));
  wire last_cmd = (cnt == wait_q - WAIT_W'(1));
  wire cmd_on   = (st_d == S_CMD);
  wire ack_on   = (st_d == S_ACK) || cmd_on;
  wire drive    = !to_mem_q && (ack_on || st_d == S_HOLD);

  always_comb begin
    st_d = st;
    case (st)
      S_IDLE: if (accept) st_d = S_WREQ;
      S_WREQ: if (drq[ch_q]) st_d = S_ARM;
      S_ARM:  st_d = drq[ch_q] ? S_ACK : S_IDLE;
      S_ACK:  st_d = S_CMD;
      S_CMD:  if (last_cmd) st_d = S_HOLD;
      S_HOLD: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmio_r <= '0;
      wait_r <= WAIT_W'(1);
    end else if (cfg_we) begin
      mmio_r <= cfg_mmio;
      wait_r <= cfg_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ch_q     <= '0;
      to_mem_q <= 1'b0;
      mm_q     <= 1'b0;
      wide_q   <= 1'b0;
      wait_q   <= WAIT_W'(1);
      wdata_q  <= '0;
      cnt      <= '0;
    end else begin
      st <= st_d;
      if (st == S_IDLE && accept) begin
        ch_q     <= gnt_ch;
        to_mem_q <= gnt_to_mem;
        mm_q     <= mmio_r[gnt_ch];
        wide_q   <= gnt_ch > CW'(GAP_CH);
        wait_q   <= (wait_r == '0) ? WAIT_W'(1) : wait_r;
        wdata_q  <= gnt_wdata;
      end
      cnt <= (st == S_CMD && cmd_on) ? cnt + WAIT_W'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dack_n   <= '1;
      ior_n    <= 1'b1;
      iow_n    <= 1'b1;
      memr_n   <= 1'b1;
      memw_n   <= 1'b1;
      lane_oe  <= 2'b00;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      dack_n   <= ack_on ? ~({{(NCH-1){1'b0}}, 1'b1} << ch_q) : '1;
      ior_n    <= !(cmd_on &&  to_mem_q && !mm_q);
      memr_n   <= !(cmd_on &&  to_mem_q &&  mm_q);
      iow_n    <= !(cmd_on && !to_mem_q && !mm_q);
      memw_n   <= !(cmd_on && !to_mem_q &&  mm_q);
      lane_oe  <= {drive && wide_q, drive};
      done     <= (st_d == S_HOLD);
      rd_valid <= (st == S_CMD) && (st_d == S_HOLD) && to_mem_q;
      if ((st == S_CMD) && (st_d == S_HOLD) && to_mem_q)
        rd_data <= wide_q ? bus_rdata : {{HW{1'b0}}, bus_rdata[HW-1:0]};
    end
  end

  assign bus_wdata = {lane_oe[1] ? wdata_q[DW-1:HW] : {HW{1'b0}},
                      lane_oe[0] ? wdata_q[HW-1:0]  : {HW{1'b0}}};

endmodule

// File: rtl/dma_bus_sequencer_checks.sv
module dma_bus_sequencer_checks #(
  parameter int NCH    = 8,
  parameter int GAP_CH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack_n,
  input logic           ior_n,
  input logic           iow_n,
  input logic           memr_n,
  input logic           memw_n,
  input logic [1:0]     lane_oe,
  input logic           rd_valid,
  input logic           done
);

  wire ack_act = |(~dack_n);
  wire cmd_act = !(ior_n && iow_n && memr_n && memw_n);
  wire wr_act  = !(iow_n && memw_n);
  wire rd_act  = !(ior_n && memr_n);

  assert_single_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));
  assert_gap_channel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dack_n[GAP_CH]);
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{ior_n, iow_n, memr_n, memw_n}));
  assert_ack_leads_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_act) |-> $past(ack_act));
  assert_ack_covers_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> ack_act);
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_act) |-> !ack_act);
  assert_ack_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_act) |=> !ack_act);
  assert_wdata_lead_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_act) |-> $past(lane_oe[0]));
  assert_wdata_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_act) |-> lane_oe[0]);
  assert_read_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> (lane_oe == 2'b00));
  assert_rd_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_act) && done));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind dma_bus_sequencer dma_bus_sequencer_checks #(.NCH(NCH), .GAP_CH(GAP_CH)) u_checks (
  .clk(clk), .rst_n(rst_n), .dack_n(dack_n), .ior_n(ior_n), .iow_n(iow_n),
  .memr_n(memr_n), .memw_n(memw_n), .lane_oe(lane_oe), .rd_valid(rd_valid),
  .done(done)
);

// File: tb/dma_bus_sequencer_bench.sv
module dma_bus_sequencer_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, gnt_valid, gnt_to_mem, cfg_we;
  logic [2:0]  gnt_ch;
  logic [15:0] gnt_wdata, bus_rdata;
  logic [7:0]  drq, cfg_mmio;
  logic [3:0]  cfg_wait;
  logic [7:0]  dack_n;
  logic        ior_n, iow_n, memr_n, memw_n, rd_valid, done;
  logic [1:0]  lane_oe;
  logic [15:0] bus_wdata, rd_data;

  dma_bus_sequencer u_dma_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .gnt_valid(gnt_valid), .gnt_ch(gnt_ch),
    .gnt_to_mem(gnt_to_mem), .gnt_wdata(gnt_wdata), .drq(drq), .cfg_we(cfg_we),
    .cfg_mmio(cfg_mmio), .cfg_wait(cfg_wait), .bus_rdata(bus_rdata),
    .dack_n(dack_n), .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
    .lane_oe(lane_oe), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done)
  );

  typedef struct packed {
    logic [7:0]  dk;
    logic [3:0]  cm;
    logic [1:0]  oe;
    logic [15:0] wd;
    logic        rv;
    logic [15:0] rd;
    logic        dn;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    total = 0, bad = 0, tcount = 0;
  int    wait_m = 1;
  logic [7:0] mmio_m = '0;

  function automatic logic [15:0] rdf(int t);
    return 16'hA5C3 ^ 16'(t * 311);
  endfunction

  function automatic exp_t idle_e();
    exp_t e;
    e = '0; e.dk = '1; e.cm = '1;
    return e;
  endfunction

  task automatic push(exp_t e, string tag);
    q.push_back(e); tq.push_back(tag);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic tick();
    exp_t e; string tag; logic ok;
    @(negedge clk);
    if (q.size() > 0) begin e = q.pop_front(); tag = tq.pop_front(); end
    else begin e = idle_e(); tag = "R12"; end
    total++;
    ok = (dack_n == e.dk) && ({ior_n, iow_n, memr_n, memw_n} == e.cm) &&
         (lane_oe == e.oe) && (done == e.dn) && (rd_valid == e.rv);
    if (e.oe[0]) ok = ok && (bus_wdata[7:0]  == e.wd[7:0]);
    if (e.oe[1]) ok = ok && (bus_wdata[15:8] == e.wd[15:8]);
    if (e.rv)    ok = ok && (rd_data == e.rd);
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0d got dack=%b cmd=%b oe=%b wd=%h rv=%b rd=%h done=%b expected dack=%b cmd=%b oe=%b wd=%h rv=%b rd=%h done=%b",
               tag, tcount, dack_n, {ior_n, iow_n, memr_n, memw_n}, lane_oe, bus_wdata,
               rd_valid, rd_data, done, e.dk, e.cm, e.oe, e.wd, e.rv, e.rd, e.dn);
    end
    tcount++;
    bus_rdata = rdf(tcount);
  endtask

  task automatic set_cfg(logic [7:0] mm, logic [3:0] w);
    cfg_we = 1'b1; cfg_mmio = mm; cfg_wait = w;
    tick();
    cfg_we = 1'b0; mmio_m = mm; wait_m = int'(w);
  endtask

  task automatic body(int ch, bit to_mem, logic [15:0] wd, int n, bit mm,
                      logic [15:0] rv, string ctag);
    exp_t a, c, h; bit wide; logic [15:0] rexp;
    wide = (ch > 4);
    rexp = wide ? rv : {8'h00, rv[7:0]};
    a = idle_e();
    a.dk = ~(8'b1 << ch);
    a.oe = to_mem ? 2'b00 : {wide, 1'b1};
    a.wd = wd;
    c = a;
    c.cm = to_mem ? (mm ? 4'b1101 : 4'b0111) : (mm ? 4'b1110 : 4'b1011);
    h = idle_e();
    h.oe = a.oe; h.wd = wd; h.dn = 1'b1; h.rv = to_mem; h.rd = rexp;
    push(a, "R2 R9");
    for (int i = 0; i < n; i++) push(c, ctag);
    push(h, to_mem ? "R10 R7 R11" : "R8 R7 R11");
  endtask

  task automatic run_xfer(int ch, bit to_mem, logic [15:0] wd, bit late, bit chg,
                          string ctag);
    int n, t1; bit mm;
    n  = (wait_m == 0) ? 1 : wait_m;
    mm = mmio_m[ch];
    gnt_valid = 1'b1; gnt_ch = 3'(ch); gnt_to_mem = to_mem; gnt_wdata = wd;
    if (!late) drq[ch] = 1'b1;
    t1 = tcount;
    push(idle_e(), "R2");
    if (!late) begin
      push(idle_e(), "R2");
      body(ch, to_mem, wd, n, mm, rdf(t1 + 3 + n), ctag);
    end
    tick();
    gnt_valid = 1'b0;
    if (late) begin
      if (chg) begin cfg_we = 1'b1; cfg_wait = 4'd4; cfg_mmio = 8'hFF; end
      tick();
      if (chg) begin cfg_we = 1'b0; wait_m = 4; mmio_m = 8'hFF; end
      tick();
      tick();
      drq[ch] = 1'b1;
      t1 = tcount;
      push(idle_e(), "R2");
      body(ch, to_mem, wd, n, mm, rdf(t1 + 2 + n), ctag);
    end else begin
      gnt_valid = 1'b1; gnt_ch = 3'((ch + 3) % 8);
      tick();
      gnt_valid = 1'b0;
    end
    while (q.size() > 0) tick();
    drq[ch] = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog: cycles=20000 expected fewer");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; gnt_valid = 1'b0; gnt_ch = '0; gnt_to_mem = 1'b0; gnt_wdata = '0;
    drq = '0; cfg_we = 1'b0; cfg_mmio = '0; cfg_wait = 4'd1; bus_rdata = rdf(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(idle_e(), "R12");
    tick();

    set_cfg(8'h00, 4'd2);
    run_xfer(1, 1'b1, 16'h1234, 1'b0, 1'b0, "R4 R6");
    run_xfer(6, 1'b0, 16'hBEEF, 1'b0, 1'b0, "R4 R6");

    set_cfg(8'h00, 4'd0);
    drq[6] = 1'b1;
    run_xfer(2, 1'b0, 16'h55A7, 1'b0, 1'b0, "R6");
    drq[6] = 1'b0;

    set_cfg(8'b0010_0000, 4'd3);
    run_xfer(5, 1'b1, 16'h0000, 1'b0, 1'b0, "R5");
    run_xfer(5, 1'b0, 16'hC0DE, 1'b0, 1'b0, "R5");
    run_xfer(0, 1'b1, 16'h0000, 1'b0, 1'b0, "R5 R4");

    // R1: channel 4 grant with its request high
    drq[4] = 1'b1; gnt_valid = 1'b1; gnt_ch = 3'd4; gnt_to_mem = 1'b1;
    for (int i = 0; i < 6; i++) push(idle_e(), "R1");
    tick();
    gnt_valid = 1'b0;
    while (q.size() > 0) tick();
    drq[4] = 1'b0;

    // R11: configuration changed after the grant; R2: late request
    set_cfg(8'h00, 4'd1);
    run_xfer(3, 1'b1, 16'h0000, 1'b1, 1'b1, "R2 R11 R6");
    run_xfer(7, 1'b1, 16'h0000, 1'b0, 1'b0, "R5 R6");
    set_cfg(8'h00, 4'd2);

    // R3: request drops before the acknowledge
    drq[1] = 1'b1; gnt_valid = 1'b1; gnt_ch = 3'd1; gnt_to_mem = 1'b0; gnt_wdata = 16'h1111;
    push(idle_e(), "R3");
    push(idle_e(), "R3");
    tick();
    gnt_valid = 1'b0;
    tick();
    drq[1] = 1'b0;
    for (int i = 0; i < 6; i++) push(idle_e(), "R3");
    while (q.size() > 0) tick();
    run_xfer(1, 1'b0, 16'h00F1, 1'b0, 1'b0, "R3 R4");

    // R7: same channel serviced twice in a row
    run_xfer(7, 1'b0, 16'h7A7A, 1'b0, 1'b0, "R7 R6");
    run_xfer(7, 1'b0, 16'h8B8B, 1'b0, 1'b0, "R7 R6");

    summary();
    $finish;
  end

endmodule